// File: doc/BRIEF.md
# Fractional-Divisor Serial Transceiver

This block is a register-mapped asynchronous serial port that sends and receives 8-bit frames: one low start bit, eight data bits sent least significant bit first, and one high stop bit. There is no parity. Software programs a 22-bit bit-rate divisor into the line register. The upper 16 bits set the whole number of clocks per oversample tick. The lower 6 bits add a fraction in steps of 1/64. A 6-bit error accumulator spreads those fractional clocks across successive ticks, so the average tick period is exact.

Software switches the global, transmit and receive enables on and off through a set alias and a clear alias. These aliases change only the bits in the written mask, so no read-modify-write is needed. Bytes pass through the data register. A write queues a byte for transmission. A read takes the oldest received byte. Two status flags report a full transmit queue and an empty receive queue. A FIFO-enable bit chooses between queues that are several entries deep and a single holding register per direction.

Top module: `uart_frac_top`

## Requirements
- R1: After reset these values hold. CTRL (address 1) reads 0. LINE (address 0) reads 0x03000100: divisor 0x000100, length field 3 (8 bits), FIFO enable 0. STAT (address 4) reads 0x2. txd is high.
- R2: The LINE layout is as follows. Bits 5:0 hold the divisor fraction. Bits 21:6 hold the divisor integer part. Bits 25:24 hold the length field. Bit 28 is the FIFO enable. A LINE write whose bits 21:0 are below 0x0000EC or above 0x3FFFC0 keeps the previous divisor but still updates bits 25:24 and 28. An in-range value is taken as written.
- R3: The CTRL bits are bit 0 global enable, bit 1 transmit enable and bit 2 receive enable. A write to address 2 ORs the mask into CTRL. A write to address 3 clears the masked bits. A write to address 1 loads CTRL. Unmasked bits keep their values.
- R4: The oversample tick period is INT clocks, plus one clock whenever the 6-bit fraction accumulator carries. A bit lasts 16 ticks. Back-to-back frames start exactly 160 ticks apart, which is 160*INT + 2.5*FRAC clocks for an even FRAC.
- R5: txd idles high. A frame starts only while the global enable and the transmit enable are both set and the transmit queue holds a byte. The frame is a low start bit, then data bits 0 through 7, then a high stop bit.
- R6: A write to DATA (address 5) queues bits 7:0 unless the transmit queue is full. A write to a full queue is dropped. STAT bit 0 is the transmit-full flag. The queue depth is 8 when the FIFO is enabled.
- R7: With LINE bit 28 clear, each queue holds a single byte. One write sets STAT bit 0, and a second write is dropped.
- R8: The receiver starts on a falling edge of rxd and confirms the start bit at mid-bit. A low pulse shorter than half a bit is rejected. Data is sampled at mid-bit. A read of DATA returns the oldest byte in bits 7:0 and removes it. STAT bit 1 is the receive-empty flag.
- R9: A received frame whose stop bit samples low is discarded.
- R10: A read of DATA while the receive queue is empty returns 0 and leaves the queue unchanged.
- R11: While the receive enable or the global enable is clear, activity on rxd queues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on the address |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The assertions take for granted that each bus access lasts a single cycle, so a DATA read pops at most one byte. They also take for granted that software never writes an out-of-range divisor into the live register. That assumption is what keeps every tick at least three clocks away from the previous one. The bench drives every access for exactly one cycle, from the falling clock edge. It drives rxd at exactly the bit period that the programmed divisor implies: 59 clocks for divisor 0xEC and 64 clocks for 0x100. It changes the divisor only while both directions are idle.

// File: rtl/uart_frac_pkg.sv
package uart_frac_pkg;
  localparam int FRAC_W = 6;
  localparam int INT_W  = 16;
  localparam int DIV_W  = INT_W + FRAC_W;
  localparam logic [DIV_W-1:0] DIV_MIN = 22'h0000EC;
  localparam logic [DIV_W-1:0] DIV_MAX = 22'h3FFFC0;

  localparam int CTRL_W   = 3;
  localparam int CB_EN    = 0;
  localparam int CB_TXE   = 1;
  localparam int CB_RXE   = 2;
  localparam int LB_WLEN  = 24;
  localparam int LB_FEN   = 28;
  localparam int SB_TXFUL = 0;
  localparam int SB_RXEMP = 1;

  typedef enum logic [2:0] {
    A_LINE = 3'd0, A_CTRL = 3'd1, A_CSET = 3'd2,
    A_CCLR = 3'd3, A_STAT = 3'd4, A_DATA = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  function automatic logic div_ok(input logic [DIV_W-1:0] d);
    return (d >= DIV_MIN) && (d <= DIV_MAX);
  endfunction

  function automatic logic [INT_W:0] tick_period(input logic [INT_W-1:0] ip,
                                                 input logic extra);
    return {1'b0, ip} + {{INT_W{1'b0}}, extra};
  endfunction

  function automatic logic [31:0] line_word(input logic [DIV_W-1:0] d,
                                            input logic [1:0] wl, input logic fe);
    logic [31:0] w;
    w = '0;
    w[DIV_W-1:0] = d;
    w[LB_WLEN +: 2] = wl;
    w[LB_FEN] = fe;
    return w;
  endfunction
endpackage

// File: rtl/uart_frac_baudgen.sv
module uart_frac_baudgen
  import uart_frac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [INT_W-1:0] div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic             tick
);
  logic [INT_W:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic            extra;
  logic [INT_W:0]  period;
  logic [FRAC_W:0] sum;

  assign period = tick_period(div_int, extra);
  assign sum    = {1'b0, acc} + {1'b0, div_frac};
  assign tick   = en && ((cnt + 1'b1) >= period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; acc <= '0; extra <= 1'b0;
    end else if (!en) begin
      cnt <= '0; acc <= '0; extra <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      acc   <= sum[FRAC_W-1:0];
      extra <= sum[FRAC_W];
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4: with the minimum legal integer part (3) no two ticks are adjacent
  p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/uart_frac_fifo.sv
module uart_frac_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         single,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = single ? (count >= CW'(1)) : (count >= CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_full_push_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (count == $past(count)));
  p_empty_pop_dropped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/uart_frac_tx.sv
module uart_frac_tx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       go_ok,
  input  logic       q_empty,
  input  logic [7:0] q_data,
  output logic       pop,
  output logic       txd
);
  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [3:0] BIT_LAST = 4'd9;

  logic             busy;
  logic [SUB_W-1:0] sub;
  logic [3:0]       bitn;
  logic [9:0]       sh;
  logic             frame_end;

  assign frame_end = busy && (sub == SUB_LAST) && (bitn == BIT_LAST);
  assign pop = tick && go_ok && !q_empty && (!busy || frame_end);
  assign txd = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sub <= '0; bitn <= '0; sh <= '1;
    end else if (pop) begin
      busy <= 1'b1; sub <= '0; bitn <= '0;
      sh   <= {1'b1, q_data, 1'b0};
    end else if (tick && busy) begin
      if (sub == SUB_LAST) begin
        sub <= '0;
        if (bitn == BIT_LAST) busy <= 1'b0;
        else begin
          bitn <= bitn + 1'b1;
          sh   <= {1'b1, sh[9:1]};
        end
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  p_start_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd) |-> $past(tick));
endmodule

// File: rtl/uart_frac_rx.sv
module uart_frac_rx
  import uart_frac_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       active,
  input  logic       rxd,
  output logic       push,
  output logic [7:0] rbyte
);
  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);

  logic             s1, s2, prev;
  rx_state_e        st;
  logic [SUB_W-1:0] sub;
  logic [2:0]       bitn;
  logic [7:0]       sh;

  assign push  = active && (st == RX_STOP) && tick && (sub == SUB_LAST) && s2;
  assign rbyte = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; prev <= 1'b1;
      st <= RX_IDLE; sub <= '0; bitn <= '0; sh <= '0;
    end else begin
      s1 <= rxd; s2 <= s1; prev <= s2;
      if (!active) st <= RX_IDLE;
      else begin
        case (st)
          RX_IDLE: if (prev && !s2) begin st <= RX_START; sub <= '0; end
          RX_START: if (tick) begin
            if (sub == SUB_MID) begin
              sub <= '0; bitn <= '0;
              st  <= s2 ? RX_IDLE : RX_DATA;
            end else sub <= sub + 1'b1;
          end
          RX_DATA: if (tick) begin
            if (sub == SUB_LAST) begin
              sub <= '0;
              sh  <= {s2, sh[7:1]};
              if (bitn == 3'd7) st <= RX_STOP;
              else bitn <= bitn + 1'b1;
            end else sub <= sub + 1'b1;
          end
          RX_STOP: if (tick) begin
            if (sub == SUB_LAST) st <= RX_IDLE;
            else sub <= sub + 1'b1;
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  p_stop_follows_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_STOP) |-> ($past(st) == RX_STOP || $past(st) == RX_DATA));
  p_push_needs_high_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (s2 && st == RX_STOP));
  p_idle_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (st == RX_IDLE));
endmodule

// File: rtl/uart_frac_top.sv
module uart_frac_top
  import uart_frac_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int OVS        = 16,
  parameter logic [21:0] RESET_DIV = 22'h000100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rxd,
  output logic        txd
);
  logic [DIV_W-1:0]  div_q;
  logic [1:0]        wlen_q;
  logic              fen_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              wr_en, rd_en;
  logic              tick;
  logic              tx_full, tx_empty, tx_pop;
  logic [7:0]        tx_head;
  logic              rx_full, rx_empty, rx_push, rx_pop;
  logic [7:0]        rx_head, rx_byte;
  logic              unused_bits;

  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && !bus_wr;
  assign rx_pop = rd_en && (bus_addr == A_DATA);
  assign unused_bits = ^{bus_wdata[31:29], bus_wdata[27:26], bus_wdata[23:22], rx_full};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= RESET_DIV; wlen_q <= 2'b11; fen_q <= 1'b0; ctrl_q <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        A_LINE: begin
          if (div_ok(bus_wdata[DIV_W-1:0])) div_q <= bus_wdata[DIV_W-1:0];
          wlen_q <= bus_wdata[LB_WLEN +: 2];
          fen_q  <= bus_wdata[LB_FEN];
        end
        A_CTRL: ctrl_q <= bus_wdata[CTRL_W-1:0];
        A_CSET: ctrl_q <= ctrl_q | bus_wdata[CTRL_W-1:0];
        A_CCLR: ctrl_q <= ctrl_q & ~bus_wdata[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_LINE: bus_rdata = line_word(div_q, wlen_q, fen_q);
      A_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
      A_STAT: begin
        bus_rdata[SB_TXFUL] = tx_full;
        bus_rdata[SB_RXEMP] = rx_empty;
      end
      A_DATA: bus_rdata[7:0] = rx_empty ? 8'h00 : rx_head;
      default: bus_rdata = '0;
    endcase
  end

  uart_frac_baudgen u_baud (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q[CB_EN]),
    .div_int(div_q[DIV_W-1:FRAC_W]), .div_frac(div_q[FRAC_W-1:0]), .tick(tick)
  );

  uart_frac_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .single(!fen_q),
    .push(wr_en && (bus_addr == A_DATA)), .pop(tx_pop), .din(bus_wdata[7:0]),
    .dout(tx_head), .full(tx_full), .empty(tx_empty)
  );

  uart_frac_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .single(!fen_q),
    .push(rx_push), .pop(rx_pop), .din(rx_byte),
    .dout(rx_head), .full(rx_full), .empty(rx_empty)
  );

  uart_frac_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .go_ok(ctrl_q[CB_EN] && ctrl_q[CB_TXE]), .q_empty(tx_empty), .q_data(tx_head),
    .pop(tx_pop), .txd(txd)
  );

  uart_frac_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .active(ctrl_q[CB_EN] && ctrl_q[CB_RXE]), .rxd(rxd),
    .push(rx_push), .rbyte(rx_byte)
  );

  p_div_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    div_ok(div_q));
  p_ctrl_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == A_CSET) |=>
      (ctrl_q == ($past(ctrl_q) | $past(bus_wdata[CTRL_W-1:0]))));
  p_ctrl_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == A_CCLR) |=>
      (ctrl_q == ($past(ctrl_q) & ~$past(bus_wdata[CTRL_W-1:0]))));
  p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));
  p_empty_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_empty) |-> (bus_rdata == 32'h0));
endmodule

// File: tb/sim_uart_frac_top.sv
module sim_uart_frac_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rxd = 1'b1;
  logic        txd;

  int checks = 0, failures = 0;
  int bit_clks = 64;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  uart_frac_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd), .txd(txd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // wait for a start bit, then sample every bit at its middle
  task automatic capture_tx(output logic [7:0] b, output bit got);
    int t = 0;
    got = 1'b0; b = '0;
    while (txd === 1'b1 && t < 20000) begin @(negedge clk); t++; end
    if (txd !== 1'b0) return;
    clocks(bit_clks / 2);
    if (txd !== 1'b0) return;
    for (int i = 0; i < 8; i++) begin clocks(bit_clks); b[i] = txd; end
    clocks(bit_clks);
    got = (txd === 1'b1);
  endtask

  task automatic line_quiet(input string req, input int n);
    int lows = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
    check(req, lows, 0);
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop);
    @(negedge clk);
    rxd = 1'b0; clocks(bit_clks);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; clocks(bit_clks); end
    rxd = stop; clocks(bit_clks);
    rxd = 1'b1; clocks(bit_clks);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd1, d); check("R1 ctrl", d, 32'h0);
    rd(3'd0, d); check("R1 line", d, 32'h03000100);
    rd(3'd4, d); check("R1 stat", d, 32'h2);
    check("R1 txd", {31'b0, txd}, 32'h1);
  endtask

  task automatic t_divisor;
    logic [31:0] d;
    wr(3'd0, 32'h130000EB); rd(3'd0, d); check("R2 below min", d, 32'h13000100);
    wr(3'd0, 32'h033FFFC1); rd(3'd0, d); check("R2 above max", d, 32'h03000100);
    wr(3'd0, 32'h133FFFC0); rd(3'd0, d); check("R2 max taken", d, 32'h133FFFC0);
    wr(3'd0, 32'h130000EC); rd(3'd0, d); check("R2 min taken", d, 32'h130000EC);
    bit_clks = 59;
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    wr(3'd2, 32'h3); rd(3'd1, d); check("R3 set 3", d, 32'h3);
    wr(3'd2, 32'h4); rd(3'd1, d); check("R3 set 4", d, 32'h7);
    wr(3'd3, 32'h2); rd(3'd1, d); check("R3 clr 2", d, 32'h5);
    wr(3'd1, 32'h6); rd(3'd1, d); check("R3 direct", d, 32'h6);
    wr(3'd3, 32'h7); rd(3'd1, d); check("R3 clr all", d, 32'h0);
  endtask

  task automatic t_tx_frame;
    logic [7:0] b; bit got;
    wr(3'd2, 32'h1);
    wr(3'd5, 32'hA5);
    line_quiet("R5 no start without TXE", 1000);
    wr(3'd2, 32'h2);
    capture_tx(b, got);
    check("R5 frame A5", {23'b0, got, b}, {23'b0, 1'b1, 8'hA5});
    wr(3'd5, 32'h3C);
    capture_tx(b, got);
    check("R5 frame 3C", {23'b0, got, b}, {23'b0, 1'b1, 8'h3C});
    clocks(bit_clks * 2);
    wr(3'd3, 32'h7);
  endtask

  task automatic measure_gap(input string req, input int exp);
    int t = 0, gap = 0;
    wr(3'd5, 32'hFF); wr(3'd5, 32'hFF);
    wr(3'd2, 32'h3);
    while (txd === 1'b1 && t < 20000) begin @(negedge clk); t++; end
    while (txd === 1'b0 && gap < 20000) begin @(negedge clk); gap++; end
    while (txd === 1'b1 && gap < 20000) begin @(negedge clk); gap++; end
    check(req, gap, exp);
    clocks(exp + 200);
    wr(3'd3, 32'h7);
  endtask

  task automatic t_timing;
    measure_gap("R4 gap div 0xEC", 590);
    wr(3'd0, 32'h13000100); bit_clks = 64;
    measure_gap("R4 gap div 0x100", 640);
    wr(3'd0, 32'h130000EC); bit_clks = 59;
  endtask

  task automatic t_fifo_full;
    logic [31:0] d; logic [7:0] b; bit got; int ok = 0;
    for (int i = 0; i < 8; i++) wr(3'd5, 32'h10 + i);
    rd(3'd4, d); check("R6 full flag", d & 32'h1, 32'h1);
    wr(3'd5, 32'hEE);
    wr(3'd2, 32'h3);
    for (int i = 0; i < 8; i++) begin
      capture_tx(b, got);
      if (got && b == 8'(8'h10 + i)) ok++;
    end
    check("R6 eight bytes in order", ok, 8);
    line_quiet("R6 dropped byte not sent", 1500);
    rd(3'd4, d); check("R6 full clears", d & 32'h1, 32'h0);
    wr(3'd3, 32'h7);
  endtask

  task automatic t_fen_off;
    logic [31:0] d; logic [7:0] b; bit got;
    wr(3'd0, 32'h030000EC);
    wr(3'd5, 32'h81);
    rd(3'd4, d); check("R7 single full", d & 32'h1, 32'h1);
    wr(3'd5, 32'h42);
    wr(3'd2, 32'h3);
    capture_tx(b, got);
    check("R7 held byte", {23'b0, got, b}, {23'b0, 1'b1, 8'h81});
    line_quiet("R7 second dropped", 1500);
    wr(3'd3, 32'h7);
    wr(3'd0, 32'h130000EC);
  endtask

  task automatic t_rx;
    logic [31:0] d;
    wr(3'd2, 32'h5);
    send_rx(8'h5A, 1'b1); send_rx(8'hC3, 1'b1);
    rd(3'd4, d); check("R8 not empty", d & 32'h2, 32'h0);
    rd(3'd5, d); check("R8 byte 5A", d, 32'h5A);
    rd(3'd5, d); check("R8 byte C3", d, 32'hC3);
    rd(3'd4, d); check("R8 empty again", d & 32'h2, 32'h2);
    @(negedge clk); rxd = 1'b0; clocks(3); rxd = 1'b1; clocks(bit_clks * 12);
    rd(3'd4, d); check("R8 glitch rejected", d & 32'h2, 32'h2);
  endtask

  task automatic t_empty_read;
    logic [31:0] d;
    rd(3'd5, d); check("R10 empty read zero", d, 32'h0);
    rd(3'd4, d); check("R10 still empty", d & 32'h2, 32'h2);
    send_rx(8'h11, 1'b1);
    rd(3'd5, d); check("R10 queue intact", d, 32'h11);
  endtask

  task automatic t_bad_stop;
    logic [31:0] d;
    send_rx(8'h77, 1'b0);
    rd(3'd4, d); check("R9 bad stop dropped", d & 32'h2, 32'h2);
    send_rx(8'h42, 1'b1);
    rd(3'd5, d); check("R9 next frame ok", d, 32'h42);
  endtask

  task automatic t_rx_off;
    logic [31:0] d;
    wr(3'd3, 32'h4);
    send_rx(8'h99, 1'b1);
    rd(3'd4, d); check("R11 rxe off ignored", d & 32'h2, 32'h2);
    wr(3'd2, 32'h4); wr(3'd3, 32'h1);
    send_rx(8'h66, 1'b1);
    rd(3'd4, d); check("R11 en off ignored", d & 32'h2, 32'h2);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    clocks(5);
    rst_n = 1'b1;
    clocks(2);
    t_reset();
    t_divisor();
    t_ctrl();
    t_tx_frame();
    t_timing();
    t_fifo_full();
    t_fen_off();
    t_rx();
    t_empty_read();
    t_bad_stop();
    t_rx_off();
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule